// File: doc/BRIEF.md
# Low-Power Coprocessor Execution Core

This block is a compact multi-cycle processor for an always-on power domain. It fetches 32-bit instruction words from a word-addressed slow memory and runs them one at a time. It has four 16-bit general registers and a 16-bit ALU. The ALU keeps a zero flag and a carry/borrow flag. The instruction set covers absolute and relative branches, indirect loads and stores, a programmable stall and a halt. Fetches and data accesses share one memory port. That port has a fixed read latency of one cycle: the data for an address driven in one cycle is on `mem_rdata` in the next cycle.

The core sits halted after reset. A one-cycle `start` pulse loads the program counter from `entry_pc` and begins execution. A stop instruction drops the core back into the halted state. An end instruction raises a one-cycle `wake` pulse or a one-cycle `timer_stop` pulse, and execution carries on with the next instruction. Opcodes that belong to neighbouring peripheral blocks are skipped. Each instruction takes three cycles: fetch, latch, execute. A load adds one cycle. A stall of N cycles adds N.

Top module: `lpcore_exec`

## Requirements
- R1: After reset, `halted` is 1 and no memory access is made. A `start` pulse loads the program counter with `entry_pc`, clears `halted` and fetches from that address.
- R2: The opcode sits in bits [31:28]: 7 ALU, 8 branch, 6 store, 13 load, 4 stall, 9 end, 11 stop. The sub-opcode sits in bits [27:25]. Register fields are dest [1:0], operand A [3:2] and operand B [5:4].
- R3: ALU sub-opcode 0 takes operand B from a register. Sub-opcode 1 takes operand B from the immediate at [19:4]. The operation field [24:21] selects 0 add, 1 subtract, 2 AND, 3 OR, 4 move, 5 shift left, 6 shift right. Move copies A in register form and the immediate in immediate form. A shift by 16 or more gives 0.
- R4: Each ALU operation sets the zero flag when the 16-bit result is 0. Add sets the overflow flag on a carry out of bit 15. Subtract sets it on a borrow (A < B). The other operations clear it.
- R5: Branch sub-opcode 0 jumps to the 11-bit address at [12:2], or to the low 11 bits of register [1:0] when bit 21 is 1. The condition at [24:22] is 0 always, 1 zero flag, 2 overflow flag.
- R6: Branch sub-opcode 1 compares R0 unsigned with the immediate at [15:0]. It takes the branch on R0 < imm when bit 16 is 0, and on R0 >= imm when bit 16 is 1. The target is PC plus the 7-bit magnitude at [23:17], or PC minus it when bit 24 is 1.
- R7: A store writes memory word (A register + offset at [20:10]) modulo 2048. The word written is {store PC[10:0], 5'b0, dest register[15:0]}.
- R8: A load reads word (A register + offset at [20:10]) and puts its low 16 bits in the dest register.
- R9: A stall instruction with count N in [15:0] adds exactly N cycles to execution.
- R10: End with sub-opcode 0 gives a one-cycle `wake` pulse when bit 0 is 1, or a one-cycle `timer_stop` pulse when bit 0 is 0. Execution then goes on at the next address.
- R11: Stop sets `halted`, which holds until the next `start`, and no memory access is made meanwhile. Opcodes 1, 2, 3, 5, 10 and end sub-opcode 1 change no register.
- R12: The program counter is 11 bits wide and wraps from 2047 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle run request |
| entry_pc | input | 11 | Word address of the first instruction |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 11 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after the access |
| halted | output | 1 | Core is stopped |
| wake | output | 1 | Wake request pulse |
| timer_stop | output | 1 | Restart-timer disable pulse |

## Verification
The assertions assume that `start` is a single-cycle pulse. They also assume that the memory returns read data in the cycle after the access and accepts writes in the same cycle. The bench memory model behaves exactly that way. The bench drives `start` for a single cycle, and only while the core is halted. Programs are placed and memory is preloaded only while the core is halted, so the bench never writes memory at the same time as the core.

// File: rtl/lpcore_pkg.sv
package lpcore_pkg;

    localparam int DW    = 16;
    localparam int AW    = 11;
    localparam int IW    = 32;
    localparam int NREG  = 4;
    localparam int RW    = $clog2(NREG);
    localparam int CNTW  = 16;
    localparam int TAGZ  = IW - AW - DW;

    localparam logic [3:0] OPC_DELAY = 4'd4;
    localparam logic [3:0] OPC_STORE = 4'd6;
    localparam logic [3:0] OPC_ALU   = 4'd7;
    localparam logic [3:0] OPC_JUMP  = 4'd8;
    localparam logic [3:0] OPC_END   = 4'd9;
    localparam logic [3:0] OPC_STOP  = 4'd11;
    localparam logic [3:0] OPC_LOAD  = 4'd13;

    localparam logic [2:0] ALU_FROM_REG = 3'd0;
    localparam logic [2:0] ALU_FROM_IMM = 3'd1;
    localparam logic [2:0] JMP_ABS      = 3'd0;
    localparam logic [2:0] JMP_REL      = 3'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LATCH,
        ST_EXEC,
        ST_LDWAIT,
        ST_STALL
    } core_state_e;

    typedef struct packed {
        logic          ok;
        logic [DW-1:0] val;
        logic          zf;
        logic          of;
    } alu_res_t;

    function automatic logic [3:0] f_opc(input logic [IW-1:0] w);
        return w[31:28];
    endfunction

    function automatic logic [2:0] f_sub(input logic [IW-1:0] w);
        return w[27:25];
    endfunction

    function automatic logic [IW-1:0] f_tagged(input logic [AW-1:0] pc,
                                               input logic [DW-1:0] v);
        return {pc, {TAGZ{1'b0}}, v};
    endfunction

endpackage

// File: rtl/lpcore_alu.sv
module lpcore_alu
    import lpcore_pkg::*;
(
    input  logic [3:0]    sel,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          move_b,
    output alu_res_t      res
);
    logic [DW:0]   sum;
    logic [DW:0]   dif;
    logic [DW-1:0] val;
    logic          ok;
    logic          of;

    always_comb begin
        sum = {1'b0, opa} + {1'b0, opb};
        dif = {1'b0, opa} - {1'b0, opb};
        ok  = 1'b1;
        of  = 1'b0;
        val = '0;
        case (sel)
            4'd0: begin val = sum[DW-1:0]; of = sum[DW]; end
            4'd1: begin val = dif[DW-1:0]; of = dif[DW]; end
            4'd2: val = opa & opb;
            4'd3: val = opa | opb;
            4'd4: val = move_b ? opb : opa;
            4'd5: val = opa << opb;
            4'd6: val = opa >> opb;
            default: ok = 1'b0;
        endcase
        res.ok  = ok;
        res.val = val;
        res.zf  = (val == '0);
        res.of  = of;
    end
endmodule

// File: rtl/lpcore_regs.sv
module lpcore_regs
    import lpcore_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [RW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [RW-1:0] ra,
    input  logic [RW-1:0] rb,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    output logic [DW-1:0] r0
);
    logic [DW-1:0] q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= '0;
            else if (we && waddr == RW'(i))
                q[i] <= wdata;
        end
    end

    assign rd_a = q[ra];
    assign rd_b = q[rb];
    assign r0   = q[0];
endmodule

// File: rtl/lpcore_jump.sv
module lpcore_jump
    import lpcore_pkg::*;
(
    input  logic [IW-1:0] ir,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] r0,
    input  logic [DW-1:0] rdest,
    input  logic          zf,
    input  logic          of,
    output logic          take,
    output logic [AW-1:0] target
);
    localparam int MAGW = 7;

    logic [2:0]      kind;
    logic            lt;
    logic [AW-1:0]   mag;

    always_comb begin
        kind   = ir[24:22];
        lt     = (r0 < ir[15:0]);
        mag    = {{(AW-MAGW){1'b0}}, ir[23:17]};
        take   = 1'b0;
        target = pc;
        case (f_sub(ir))
            JMP_ABS: begin
                case (kind)
                    3'd0:    take = 1'b1;
                    3'd1:    take = zf;
                    3'd2:    take = of;
                    default: take = 1'b0;
                endcase
                target = ir[21] ? rdest[AW-1:0] : ir[12:2];
            end
            JMP_REL: begin
                take   = ir[16] ? !lt : lt;
                target = ir[24] ? (pc - mag) : (pc + mag);
            end
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/lpcore_exec.sv
module lpcore_exec
    import lpcore_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [10:0]   entry_pc,
    output logic          mem_en,
    output logic          mem_we,
    output logic [10:0]   mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          halted,
    output logic          wake,
    output logic          timer_stop
);
    core_state_e     state;
    logic [AW-1:0]   pc;
    logic [IW-1:0]   ir;
    logic [CNTW-1:0] cnt;
    logic            zf_q, of_q;
    logic            wake_q, tstop_q;

    logic [3:0]      opc;
    logic [2:0]      sub;
    logic [RW-1:0]   rb_sel;
    logic [DW-1:0]   rd_a, rd_b, r0;
    logic [DW-1:0]   opb;
    alu_res_t        alu;
    logic            alu_act;
    logic            rf_we;
    logic [DW-1:0]   rf_wd;
    logic            take;
    logic [AW-1:0]   target;
    logic [AW-1:0]   data_addr;
    logic            in_exec;

    assign opc     = f_opc(ir);
    assign sub     = f_sub(ir);
    assign in_exec = (state == ST_EXEC);
    assign rb_sel  = (opc == OPC_ALU && sub == ALU_FROM_REG) ? ir[5:4] : ir[1:0];
    assign opb     = (sub == ALU_FROM_IMM) ? ir[19:4] : rd_b;

    lpcore_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (ir[1:0]),
        .wdata (rf_wd),
        .ra    (ir[3:2]),
        .rb    (rb_sel),
        .rd_a  (rd_a),
        .rd_b  (rd_b),
        .r0    (r0)
    );

    lpcore_alu u_alu (
        .sel    (ir[24:21]),
        .opa    (rd_a),
        .opb    (opb),
        .move_b (sub == ALU_FROM_IMM),
        .res    (alu)
    );

    lpcore_jump u_jump (
        .ir     (ir),
        .pc     (pc),
        .r0     (r0),
        .rdest  (rd_b),
        .zf     (zf_q),
        .of     (of_q),
        .take   (take),
        .target (target)
    );

    assign alu_act = in_exec && opc == OPC_ALU && alu.ok &&
                     (sub == ALU_FROM_REG || sub == ALU_FROM_IMM);
    assign rf_we   = alu_act || (state == ST_LDWAIT);
    assign rf_wd   = (state == ST_LDWAIT) ? mem_rdata[DW-1:0] : alu.val;

    assign data_addr = rd_a[AW-1:0] + ir[20:10];

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = pc;
        mem_wdata = '0;
        if (state == ST_FETCH) begin
            mem_en = 1'b1;
        end else if (in_exec && opc == OPC_STORE) begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = data_addr;
            mem_wdata = f_tagged(pc, rd_b);
        end else if (in_exec && opc == OPC_LOAD) begin
            mem_en   = 1'b1;
            mem_addr = data_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pc      <= '0;
            ir      <= '0;
            cnt     <= '0;
            zf_q    <= 1'b0;
            of_q    <= 1'b0;
            wake_q  <= 1'b0;
            tstop_q <= 1'b0;
        end else begin
            wake_q  <= 1'b0;
            tstop_q <= 1'b0;
            if (start) begin
                pc    <= entry_pc;
                state <= ST_FETCH;
            end else begin
                case (state)
                    ST_IDLE:  state <= ST_IDLE;
                    ST_FETCH: state <= ST_LATCH;
                    ST_LATCH: begin
                        ir    <= mem_rdata;
                        state <= ST_EXEC;
                    end
                    ST_EXEC: begin
                        state <= ST_FETCH;
                        pc    <= pc + 1'b1;
                        case (opc)
                            OPC_ALU: begin
                                if (alu_act) begin
                                    zf_q <= alu.zf;
                                    of_q <= alu.of;
                                end
                            end
                            OPC_JUMP: begin
                                if (take) pc <= target;
                            end
                            OPC_LOAD: begin
                                pc    <= pc;
                                state <= ST_LDWAIT;
                            end
                            OPC_DELAY: begin
                                if (ir[CNTW-1:0] != '0) begin
                                    pc    <= pc;
                                    cnt   <= ir[CNTW-1:0];
                                    state <= ST_STALL;
                                end
                            end
                            OPC_END: begin
                                if (sub == 3'd0) begin
                                    if (ir[0]) wake_q  <= 1'b1;
                                    else       tstop_q <= 1'b1;
                                end
                            end
                            OPC_STOP: begin
                                pc    <= pc;
                                state <= ST_IDLE;
                            end
                            default: ;
                        endcase
                    end
                    ST_LDWAIT: begin
                        pc    <= pc + 1'b1;
                        state <= ST_FETCH;
                    end
                    ST_STALL: begin
                        if (cnt == CNTW'(1)) begin
                            pc    <= pc + 1'b1;
                            state <= ST_FETCH;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign halted     = (state == ST_IDLE);
    assign wake       = wake_q;
    assign timer_stop = tstop_q;

endmodule

// File: rtl/lpcore_exec_chk.sv
module lpcore_exec_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        mem_en,
    input logic        mem_we,
    input logic [31:0] mem_wdata,
    input logic        halted,
    input logic        wake,
    input logic        timer_stop
);
    // R1
    idle_no_access_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_en);

    // R1
    start_runs_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !halted);

    // R11
    halt_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (halted && !start) |=> halted);

    // R7
    store_format_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_en && mem_wdata[20:16] == 5'd0));

    // R10
    wake_single_chk: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake);

    // R10
    end_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(wake && timer_stop));
endmodule

bind lpcore_exec lpcore_exec_chk u_chk (.*);

// File: tb/lpcore_exec_test.sv
module lpcore_exec_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [10:0] entry_pc = '0;
    logic        mem_en, mem_we;
    logic [10:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        halted, wake, timer_stop;

    localparam logic [31:0] MARK = 32'hDEAD_BEEF;

    int total = 0;
    int failed = 0;
    bit done = 0;

    logic [31:0] mem [2048];

    always #5 clk = ~clk;

    lpcore_exec uut (
        .clk(clk), .rst(rst), .start(start), .entry_pc(entry_pc),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .halted(halted), .wake(wake), .timer_stop(timer_stop)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            mem_rdata <= mem[mem_addr];
        end
    end

    function automatic logic [31:0] i_alur(int sel, int d, int s, int t);
        return {4'd7, 3'd0, 4'(sel), 15'd0, 2'(t), 2'(s), 2'(d)};
    endfunction
    function automatic logic [31:0] i_alui(int sel, int d, int s, logic [15:0] imm);
        return {4'd7, 3'd1, 4'(sel), 1'b0, imm, 2'(s), 2'(d)};
    endfunction
    function automatic logic [31:0] i_bx(int kind, bit rmode, int d, int addr);
        return {4'd8, 3'd0, 3'(kind), rmode, 8'd0, 11'(addr), 2'(d)};
    endfunction
    function automatic logic [31:0] i_brel(bit ge, bit back, int mag, logic [15:0] imm);
        return {4'd8, 3'd1, back, 7'(mag), ge, imm};
    endfunction
    function automatic logic [31:0] i_st(int d, int s, int off);
        return {4'd6, 3'd4, 4'd0, 11'(off), 6'd0, 2'(s), 2'(d)};
    endfunction
    function automatic logic [31:0] i_ld(int d, int s, int off);
        return {4'd13, 7'd0, 11'(off), 6'd0, 2'(s), 2'(d)};
    endfunction
    function automatic logic [31:0] i_delay(int n);
        return {4'd4, 12'd0, 16'(n)};
    endfunction
    function automatic logic [31:0] i_end(int sub, bit w);
        return {4'd9, 3'(sub), 24'd0, w};
    endfunction
    function automatic logic [31:0] i_stop();
        return {4'd11, 28'd0};
    endfunction
    function automatic logic [31:0] tag(int pc, logic [15:0] v);
        return {11'(pc), 5'd0, v};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    int last_cycles, last_wakes, last_tstops;

    task automatic run(int entry);
        int cyc = 0;
        last_wakes = 0;
        last_tstops = 0;
        @(negedge clk);
        entry_pc = 11'(entry);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!halted) begin
            @(negedge clk);
            cyc++;
            if (wake) last_wakes++;
            if (timer_stop) last_tstops++;
            if (cyc > 20000) begin
                total++;
                failed++;
                $display("FAIL R1 run from %0d did not halt actual=%0d expected=halt", entry, cyc);
                break;
            end
        end
        last_cycles = cyc;
    endtask

    function automatic logic [15:0] model(int sel, logic [15:0] a, logic [15:0] b, bit imm);
        case (sel)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return imm ? b : a;
            5: return (b >= 16) ? 16'd0 : (a << b);
            default: return (b >= 16) ? 16'd0 : (a >> b);
        endcase
    endfunction

    initial begin
        logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                                  16'hFFFF, 16'h1234, 16'h0003, 16'h0010};
        logic [15:0] rv [6] = '{16'h0000, 16'h0001, 16'h0005, 16'h7FFF,
                                16'h8000, 16'hFFFF};
        for (int i = 0; i < 2048; i++) mem[i] = i_stop();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 halted after reset", 32'(halted), 32'd1);
        check("R1 no access after reset", 32'(mem_en), 32'd0);
        check("R10 no wake after reset", 32'(wake), 32'd0);

        // R2 R3 R4: sweep of ALU operations and operand pairs
        for (int sel = 0; sel < 7; sel++) begin
            for (int ia = 0; ia < 8; ia++) begin
                for (int ib = 0; ib < 8; ib++) begin
                    logic [15:0] a, b, r;
                    logic [16:0] wide;
                    bit z, o;
                    a = vals[ia];
                    b = vals[ib];
                    mem[0]  = i_alui(4, 0, 0, 16'd0);
                    mem[1]  = i_alui(4, 1, 0, a);
                    mem[2]  = i_alui(4, 2, 0, b);
                    mem[3]  = i_alur(sel, 3, 1, 2);
                    mem[4]  = i_st(3, 0, 100);
                    mem[5]  = i_bx(1, 1'b0, 0, 7);
                    mem[6]  = i_bx(0, 1'b0, 0, 8);
                    mem[7]  = i_st(0, 0, 101);
                    mem[8]  = i_bx(2, 1'b0, 0, 10);
                    mem[9]  = i_bx(0, 1'b0, 0, 11);
                    mem[10] = i_st(0, 0, 102);
                    mem[11] = i_alui(sel, 3, 1, b);
                    mem[12] = i_st(3, 0, 103);
                    mem[13] = i_stop();
                    for (int k = 100; k < 104; k++) mem[k] = MARK;
                    run(0);
                    r = model(sel, a, b, 1'b0);
                    z = (r == 16'd0);
                    o = 1'b0;
                    if (sel == 0) begin wide = {1'b0, a} + {1'b0, b}; o = wide[16]; end
                    if (sel == 1) o = (a < b);
                    check($sformatf("R3 reg-form sel=%0d a=%h b=%h", sel, a, b), mem[100], tag(4, r));
                    check($sformatf("R4 zero flag sel=%0d a=%h b=%h", sel, a, b), mem[101], z ? tag(7, 16'd0) : MARK);
                    check($sformatf("R4 overflow flag sel=%0d a=%h b=%h", sel, a, b), mem[102], o ? tag(10, 16'd0) : MARK);
                    check($sformatf("R3 imm-form sel=%0d a=%h b=%h", sel, a, b), mem[103], tag(12, model(sel, a, b, 1'b1)));
                end
            end
        end

        // R6: relative branch forward, both comparisons
        for (int cmp = 0; cmp < 2; cmp++) begin
            for (int iv = 0; iv < 6; iv++) begin
                for (int ii = 0; ii < 6; ii++) begin
                    bit tk;
                    mem[20] = i_alui(4, 2, 0, 16'd0);
                    mem[21] = i_alui(4, 0, 0, rv[iv]);
                    mem[22] = i_brel(cmp[0], 1'b0, 3, rv[ii]);
                    mem[23] = i_st(0, 2, 110);
                    mem[24] = i_stop();
                    mem[25] = i_st(0, 2, 111);
                    mem[26] = i_stop();
                    mem[110] = MARK;
                    mem[111] = MARK;
                    run(20);
                    tk = (cmp == 0) ? (rv[iv] < rv[ii]) : (rv[iv] >= rv[ii]);
                    check($sformatf("R6 taken path cmp=%0d r0=%h imm=%h", cmp, rv[iv], rv[ii]),
                          mem[111], tk ? tag(25, rv[iv]) : MARK);
                    check($sformatf("R6 fall path cmp=%0d r0=%h imm=%h", cmp, rv[iv], rv[ii]),
                          mem[110], tk ? MARK : tag(23, rv[iv]));
                end
            end
        end

        // R6: backward relative branch loop
        mem[40] = i_alui(4, 2, 0, 16'd0);
        mem[41] = i_alui(4, 0, 0, 16'd0);
        mem[42] = i_bx(0, 1'b0, 0, 45);
        mem[43] = i_st(0, 2, 112);
        mem[44] = i_stop();
        mem[45] = i_alui(0, 0, 0, 16'd1);
        mem[46] = i_brel(1'b0, 1'b1, 1, 16'd3);
        mem[47] = i_bx(0, 1'b0, 0, 43);
        mem[112] = MARK;
        run(40);
        check("R6 backward loop count", mem[112], tag(43, 16'd3));

        // R5: absolute jump through a register
        mem[60] = i_alui(4, 2, 0, 16'd0);
        mem[61] = i_alui(4, 1, 0, 16'd66);
        mem[62] = i_bx(0, 1'b1, 1, 0);
        mem[63] = i_st(1, 2, 113);
        mem[64] = i_stop();
        mem[66] = i_st(1, 2, 114);
        mem[67] = i_stop();
        mem[113] = MARK;
        mem[114] = MARK;
        run(60);
        check("R5 register target reached", mem[114], tag(66, 16'd66));
        check("R5 register jump skips next", mem[113], MARK);

        // R8: load low half then store it
        mem[200] = 32'h5A5A_1357;
        mem[80] = i_alui(4, 2, 0, 16'd190);
        mem[81] = i_ld(3, 2, 10);
        mem[82] = i_st(3, 2, 20);
        mem[83] = i_stop();
        mem[210] = MARK;
        run(80);
        check("R8 load low half", mem[210], tag(82, 16'h1357));
        check("R7 source word kept by load", mem[200], 32'h5A5A_1357);

        // R9: stall cycles relative to zero stall
        begin
            int base;
            int ns [5] = '{1, 2, 7, 40, 300};
            mem[300] = i_delay(0);
            mem[301] = i_stop();
            run(300);
            base = last_cycles;
            foreach (ns[j]) begin
                mem[300] = i_delay(ns[j]);
                run(300);
                check($sformatf("R9 stall %0d extra cycles", ns[j]), 32'(last_cycles - base), 32'(ns[j]));
            end
        end

        // R10: wake and timer-stop pulses, execution continues
        mem[320] = i_alui(4, 2, 0, 16'd0);
        mem[321] = i_end(0, 1'b1);
        mem[322] = i_end(0, 1'b0);
        mem[323] = i_st(2, 2, 115);
        mem[324] = i_stop();
        mem[115] = MARK;
        run(320);
        check("R10 one wake pulse", 32'(last_wakes), 32'd1);
        check("R10 one timer-stop pulse", 32'(last_tstops), 32'd1);
        check("R10 continues after end", mem[115], tag(323, 16'd0));

        // R11: skipped opcodes leave registers alone
        mem[340] = i_alui(4, 3, 0, 16'h4321);
        mem[341] = i_alui(4, 2, 0, 16'd0);
        mem[342] = {4'd1, 28'h5A5A5A7};
        mem[343] = {4'd2, 28'h5A5A5A7};
        mem[344] = {4'd3, 28'h5A5A5A7};
        mem[345] = {4'd5, 28'h5A5A5A7};
        mem[346] = {4'd10, 28'h5A5A5A7};
        mem[347] = i_end(1, 1'b1);
        mem[348] = i_st(3, 2, 116);
        mem[349] = i_stop();
        mem[116] = MARK;
        run(340);
        check("R11 skipped opcodes keep R3", mem[116], tag(348, 16'h4321));
        check("R11 skipped end sub1 gives no wake", 32'(last_wakes), 32'd0);

        // R11: halted holds with no memory access
        begin
            int acc = 0;
            int up = 0;
            for (int c = 0; c < 12; c++) begin
                @(negedge clk);
                if (mem_en) acc++;
                if (halted) up++;
            end
            check("R11 no access while halted", 32'(acc), 32'd0);
            check("R11 halted holds", 32'(up), 32'd12);
        end

        // R12: program counter wrap
        mem[2046] = i_alui(4, 2, 0, 16'd0);
        mem[2047] = i_alui(4, 3, 0, 16'h0077);
        mem[0]    = i_st(3, 2, 120);
        mem[1]    = i_stop();
        mem[120]  = MARK;
        run(2046);
        check("R12 wrap to address 0", mem[120], tag(0, 16'h0077));

        // R7: store address wraps modulo 2048
        mem[400] = i_alui(4, 1, 0, 16'hFFFF);
        mem[401] = i_st(1, 1, 5);
        mem[402] = i_stop();
        mem[4] = MARK;
        run(400);
        check("R7 store address wraps", mem[4], tag(401, 16'hFFFF));

        done = 1;
        $display("  %0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!done) begin
            total++;
            failed++;
            $display("FAIL R1 watchdog expired actual=running expected=finished");
            $display("  %0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end
endmodule